// File: doc/BRIEF.md
# Vector widening unsigned shift-left unit

This block takes a 128-bit vector operand and turns one 64-bit half of it into a full 128-bit vector of double-width lanes. Each narrow element of the chosen half is treated as an unsigned number. It is padded with zeros to twice its width and then moved left by an immediate amount. The vacated low bits are filled with zeros. Element i of the chosen half lands in destination lane i.

A request arrives as `in_valid` together with the operand, a 2-bit element-size code, a half-select flag and the shift amount. The result comes back on `out_data` with `out_valid` one clock later. `out_err` flags a request that is illegal, either because the size code is reserved or because the shift is not smaller than the source element width. An illegal request returns an all-zero result.

Top module: `vwiden_shl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` is low after that edge.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: Size code 00 treats the half as eight 8-bit elements. Lane i of `out_data` is bits [16i+15:16i] and equals element i (bits [8i+7:8i] of the half), zero-extended and multiplied by 2^shift.
- R4: Size code 01 treats the half as four 16-bit elements. Lane i is bits [32i+31:32i] and equals element i, zero-extended and multiplied by 2^shift.
- R5: Size code 10 treats the half as two 32-bit elements. Lane i is bits [64i+63:64i] and equals element i, zero-extended and multiplied by 2^shift.
- R6: With `in_upper` = 0 the elements come from `in_src[63:0]`. With `in_upper` = 1 they come from `in_src[127:64]`. The unselected half has no effect on `out_data`.
- R7: A shift of 0 returns each element zero-extended into its double-width lane, unchanged in value.
- R8: For a legal size code, a shift amount greater than or equal to the source element width (8, 16 or 32) sets `out_err` to 1 and forces `out_data` to zero.
- R9: Size code 11 sets `out_err` to 1 and forces `out_data` to zero, whatever the shift amount is.
- R10: A legal request (size code below 11, shift below the element width) clears `out_err`. In every lane, all bits at and above position (element width + shift) are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_src | input | 128 | Source vector |
| in_size | input | 2 | Source element size code (00 = 8, 01 = 16, 10 = 32, 11 = reserved) |
| in_upper | input | 1 | Half select: 0 = bits [63:0], 1 = bits [127:64] |
| in_shamt | input | 5 | Left shift amount |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 128 | Widened and shifted vector |
| out_err | output | 1 | Illegal request flag |

## Verification
The bench sweeps every size code, both halves and every shift amount from 0 to 31. It uses several data patterns whose two halves differ, so a design that read the wrong half, or let the other half leak in, returns lanes that do not match. The all-ones pattern at the largest legal shift is aimed at a design that drops the zero-extension or does the shift in the narrow width. Such a design loses top bits or smears bits into the neighbouring lane. Shifts equal to the element width, and the reserved size code, catch a design that skips the error flag or lets a stale or partial result through.

// File: rtl/vwiden_pkg.sv
package vwiden_pkg;

   typedef enum logic [1:0] {
      ESZ_8   = 2'b00,
      ESZ_16  = 2'b01,
      ESZ_32  = 2'b10,
      ESZ_BAD = 2'b11
   } esz_e;

   localparam int unsigned NUM_SIZES = 3;

   function automatic int unsigned elem_bits(input esz_e code);
      case (code)
         ESZ_8:   elem_bits = 8;
         ESZ_16:  elem_bits = 16;
         ESZ_32:  elem_bits = 32;
         default: elem_bits = 0;
      endcase
   endfunction

endpackage

// File: rtl/vwiden_half.sv
module vwiden_half #(
   parameter int unsigned VEC_W = 128,
   localparam int unsigned HALF_W = VEC_W / 2
) (
   input  logic [VEC_W-1:0]  src,
   input  logic              upper,
   output logic [HALF_W-1:0] half
);
   assign half = upper ? src[VEC_W-1:HALF_W] : src[HALF_W-1:0];
endmodule

// File: rtl/vwiden_lane.sv
module vwiden_lane #(
   parameter int unsigned ESZ  = 8,
   parameter int unsigned SH_W = 5
) (
   input  logic [ESZ-1:0]   elem,
   input  logic [SH_W-1:0]  shamt,
   output logic [2*ESZ-1:0] res
);
   logic [2*ESZ-1:0] wide;

   assign wide = {{ESZ{1'b0}}, elem};
   assign res  = wide << shamt;
endmodule

// File: rtl/vwiden_group.sv
module vwiden_group #(
   parameter int unsigned HALF_W = 64,
   parameter int unsigned ESZ    = 8,
   parameter int unsigned SH_W   = 5,
   localparam int unsigned NL    = HALF_W / ESZ
) (
   input  logic [HALF_W-1:0]   half,
   input  logic [SH_W-1:0]     shamt,
   output logic [2*HALF_W-1:0] res
);
   for (genvar i = 0; i < NL; i++) begin : g_lane
      vwiden_lane #(
         .ESZ  (ESZ),
         .SH_W (SH_W)
      ) u_lane (
         .elem  (half[i*ESZ +: ESZ]),
         .shamt (shamt),
         .res   (res[i*2*ESZ +: 2*ESZ])
      );
   end
endmodule

// File: rtl/vwiden_legal.sv
module vwiden_legal
   import vwiden_pkg::*;
#(
   parameter int unsigned SH_W = 5
) (
   input  logic [1:0]      size,
   input  logic [SH_W-1:0] shamt,
   output logic            err
);
   esz_e        code;
   int unsigned width;

   always_comb begin
      code  = esz_e'(size);
      width = elem_bits(code);
      err   = (code == ESZ_BAD) || (32'(shamt) >= width);
   end
endmodule

// File: rtl/vwiden_shl.sv
module vwiden_shl
   import vwiden_pkg::*;
#(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned SH_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] in_src,
   input  logic [1:0]       in_size,
   input  logic             in_upper,
   input  logic [SH_W-1:0]  in_shamt,
   output logic             out_valid,
   output logic [VEC_W-1:0] out_data,
   output logic             out_err
);
   localparam int unsigned HALF_W = VEC_W / 2;

   if ((VEC_W % 64) != 0 || VEC_W < 64) begin : g_bad_width
      $error("vwiden_shl: VEC_W must be a nonzero multiple of 64");
   end
   if ((1 << SH_W) < 32) begin : g_bad_shift
      $error("vwiden_shl: SH_W too narrow for 32-bit elements");
   end

   logic [HALF_W-1:0] half;
   logic [VEC_W-1:0]  grp_res [NUM_SIZES];
   logic [VEC_W-1:0]  sel_res;
   logic              req_err;

   vwiden_half #(.VEC_W(VEC_W)) u_half (
      .src   (in_src),
      .upper (in_upper),
      .half  (half)
   );

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      vwiden_group #(
         .HALF_W (HALF_W),
         .ESZ    (8 << g),
         .SH_W   (SH_W)
      ) u_group (
         .half  (half),
         .shamt (in_shamt),
         .res   (grp_res[g])
      );
   end

   vwiden_legal #(.SH_W(SH_W)) u_legal (
      .size  (in_size),
      .shamt (in_shamt),
      .err   (req_err)
   );

   always_comb begin
      case (esz_e'(in_size))
         ESZ_8:   sel_res = grp_res[0];
         ESZ_16:  sel_res = grp_res[1];
         ESZ_32:  sel_res = grp_res[2];
         default: sel_res = '0;
      endcase
      if (req_err) sel_res = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         out_data <= sel_res;
         out_err  <= req_err;
      end
   end
endmodule

// File: rtl/vwiden_shl_chk.sv
module vwiden_shl_chk #(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned SH_W  = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [VEC_W-1:0] in_src,
   input logic [1:0]       in_size,
   input logic             in_upper,
   input logic [SH_W-1:0]  in_shamt,
   input logic             out_valid,
   input logic [VEC_W-1:0] out_data,
   input logic             out_err
);
   localparam int unsigned HALF_W = VEC_W / 2;

   logic [31:0] sh_ext;
   logic [31:0] ew;
   logic [31:0] pick32;

   assign sh_ext = 32'(in_shamt);
   assign ew     = 32'd8 << in_size;
   assign pick32 = in_upper ? in_src[HALF_W +: 32] : in_src[31:0];

   // R2: the valid strobe follows the request by one cycle
   assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R9: a reserved size code gives an error and a zero result
   assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_size == 2'b11) |=> (out_err && out_data == '0));

   // R8: an oversized shift on a legal size code raises the error
   assert_big_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_size != 2'b11 && sh_ext >= ew) |=> (out_err && out_data == '0));

   // R10: a legal request never raises the error
   assert_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_size != 2'b11 && sh_ext < ew) |=> !out_err);

   // R6, R7: a zero shift on words copies the selected half's low word into lane 0
   assert_zero_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_size == 2'b10 && in_shamt == '0)
      |=> (out_data[63:0] == {32'b0, $past(pick32)}));
endmodule

bind vwiden_shl vwiden_shl_chk #(
   .VEC_W (VEC_W),
   .SH_W  (SH_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_src    (in_src),
   .in_size   (in_size),
   .in_upper  (in_upper),
   .in_shamt  (in_shamt),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_err   (out_err)
);

// File: tb/vwiden_shl_tb.sv
`timescale 1ns/1ps
module vwiden_shl_tb;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [127:0] in_src;
   logic [1:0]   in_size;
   logic         in_upper;
   logic [4:0]   in_shamt;
   logic         out_valid;
   logic [127:0] out_data;
   logic         out_err;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   vwiden_shl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_src    (in_src),
      .in_size   (in_size),
      .in_upper  (in_upper),
      .in_shamt  (in_shamt),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_err   (out_err)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // reference: per-lane arithmetic, element value times 2^shift
   function automatic logic [127:0] model(input logic [127:0] src, input int sz,
                                          input bit up, input int sh);
      logic [127:0] half, e, r, acc;
      int ew, n;
      acc = '0;
      if (sz == 3) return acc;
      ew = 8 << sz;
      if (sh >= ew) return acc;
      n = 64 / ew;
      half = up ? (src >> 64) : (src & {64'b0, {64{1'b1}}});
      for (int i = 0; i < n; i++) begin
         e = (half >> (i * ew)) & ((128'd1 << ew) - 128'd1);
         r = e * (128'd1 << sh);
         acc = acc | (r << (i * 2 * ew));
      end
      return acc;
   endfunction

   function automatic logic [127:0] pattern(input int k);
      logic [127:0] p;
      case (k)
         0: p = {128{1'b1}};
         1: p = {64'h0123_4567_89AB_CDEF, 64'h5A5A_A5A5_F00F_0FF0};
         2: p = {$urandom, $urandom, $urandom, $urandom};
         default: begin
            p = '0;
            for (int j = 0; j < 16; j++) p[j*8 +: 8] = 8'(j * 17 + 3);
         end
      endcase
      return p;
   endfunction

   task automatic issue(input logic [127:0] src, input int sz, input bit up, input int sh);
      logic [127:0] exp, lane;
      bit           exp_err;
      int           ew;
      string        req;
      in_valid = 1'b1;
      in_src   = src;
      in_size  = 2'(sz);
      in_upper = up;
      in_shamt = 5'(sh);
      @(negedge clk);
      ew      = 8 << sz;
      exp     = model(src, sz, up, sh);
      exp_err = (sz == 3) || (sh >= ew);
      chk(out_valid == 1'b1, "R2 valid after request", 128'(out_valid), 128'd1);
      if (sz == 3)       req = "R9 reserved size";
      else if (exp_err)  req = "R8 oversized shift";
      else if (sh == 0)  req = "R7 zero shift / R6 half";
      else if (sz == 0)  req = "R3 byte lanes / R6 half";
      else if (sz == 1)  req = "R4 half lanes / R6 half";
      else               req = "R5 word lanes / R6 half";
      chk(out_err == exp_err, {req, " err"}, 128'(out_err), 128'(exp_err));
      chk(out_data == exp, {req, " data"}, out_data, exp);
      if (!exp_err) begin
         for (int i = 0; i < 64 / ew; i++) begin
            lane = (out_data >> (i * 2 * ew)) & ((128'd1 << (2 * ew)) - 128'd1);
            chk((lane >> (ew + sh)) == '0, "R10 lane fits", lane, 128'd0);
         end
      end
   endtask

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b1;
      in_src   = '0;
      in_size  = '0;
      in_upper = 1'b0;
      in_shamt = '0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1 reset clears valid", 128'(out_valid), 128'd0);
      in_valid = 1'b0;
      rst_n    = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 idle after reset", 128'(out_valid), 128'd0);

      for (int sz = 0; sz < 4; sz++) begin
         for (int up = 0; up < 2; up++) begin
            for (int k = 0; k < 4; k++) begin
               for (int sh = 0; sh < 32; sh++) begin
                  issue(pattern(k), sz, up[0], sh);
               end
            end
         end
         in_valid = 1'b0;
         @(negedge clk);
         chk(out_valid == 1'b0, "R2 valid drops when idle", 128'(out_valid), 128'd0);
      end

      // R6: changing only the unselected half leaves the result unchanged
      issue({64'hFFFF_FFFF_FFFF_FFFF, 64'h1122_3344_5566_7788}, 0, 1'b0, 3);
      issue({64'h0000_0000_0000_0000, 64'h1122_3344_5566_7788}, 0, 1'b0, 3);
      issue({64'h8877_6655_4433_2211, 64'hDEAD_BEEF_DEAD_BEEF}, 2, 1'b1, 31);
      issue({64'h8877_6655_4433_2211, 64'h0000_0000_0000_0000}, 2, 1'b1, 31);
      in_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule